// File: doc/BRIEF.md
# Three-Phase Voltage Sag Monitor

The block watches three phase-voltage sample streams and raises a per-phase sag flag when a phase has stayed low for a chosen number of samples in a row. Each sample strobe delivers one signed sample for each phase. A phase counts as low when the absolute value of its sample is below a threshold. The flag sets only after the programmed run of low samples. It drops on the first sample that is not low.

Phase A also drives a square wave at the line fundamental. The wave goes high when the sample is clearly positive and low when it is clearly negative. Inside a small band around zero it holds its value, so noise near the zero crossing does not add toggles.

The three flags and the wave are packed into a 32-bit status word. That word is latched one clock after each strobe, so between strobes the host sees the result of the pass that has just finished. A one-cycle interrupt pulse marks each update. Threshold and count are plain inputs and are sampled on every strobe.

Top module: `sag_status_monitor`

## Requirements
- R1: After reset, status_o is all zeros and irq_o is low.
- R2: Bits 31 to 4 of status_o always read zero.
- R3: A phase's sag flag becomes one on the strobe that completes L consecutive low samples, where L = count_i (or 1 when count_i is 0). A sample is low when its absolute value is strictly less than thresh_i. The flag stays zero before that strobe.
- R4: A sample whose absolute value is equal to or greater than thresh_i clears that phase's flag and its run count on that strobe. Low samples that follow keep the flag set.
- R5: With count_i at 0 or 1, the first low sample sets the flag.
- R6: Negative samples are judged by their absolute value. The most negative code, -32768 at the default width, has magnitude 32768.
- R7: Status bit 3 is the fundamental wave. It becomes 1 on a strobe with phase A above +HYST and becomes 0 on a strobe with phase A below -HYST. Otherwise it holds. It is 0 after reset.
- R8: status_o changes only on the clock edge that follows a strobe, and then shows the flags and wave computed on that strobe. In the cycle between the strobe edge and that edge it still shows the previous pass.
- R9: irq_o is high for exactly the one cycle after status_o has been updated, that is, in the second cycle after the strobe edge.
- R10: Bit 0 holds the phase A flag, bit 1 the phase B flag and bit 2 the phase C flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle pulse marking a valid sample set |
| samp_a_i | input | SAMPLE_W | Phase A signed sample |
| samp_b_i | input | SAMPLE_W | Phase B signed sample |
| samp_c_i | input | SAMPLE_W | Phase C signed sample |
| thresh_i | input | SAMPLE_W | Unsigned sag threshold on sample magnitude |
| count_i | input | CNT_W | Number of consecutive low samples needed to flag a sag |
| status_o | output | 32 | Packed status word from the last pass |
| irq_o | output | 1 | One-cycle pulse when status_o updates |

## Verification
Each fault shows up in status_o within two clocks of the strobe that exposes it:
- A run counter that is off by one or fails to clear sets a flag one pass early or late.
- A flag that does not clear keeps its bit high after a sample at or above the threshold.
- A wrong magnitude calculation mis-classifies negative samples, most visibly the most negative code.
- A broken hysteresis band adds or drops toggles of bit 3 as phase A moves through the band.
- Pipeline faults move the status change or the interrupt pulse by one cycle, or let status_o change with no strobe.

// File: rtl/sag_mon_pkg.sv
package sag_mon_pkg;
  localparam int STATUS_W  = 32;
  localparam int NUM_PH    = 3;
  localparam int WAVE_BIT  = 3;
  localparam int USED_BITS = WAVE_BIT + 1;
endpackage

// File: rtl/sag_phase_det.sv
module sag_phase_det #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  input  logic        [CNT_W-1:0]    count_i,
  output logic                       sag_o
);
  localparam int MAG_W = SAMPLE_W + 1;

  logic [MAG_W-1:0] mag;
  logic             is_low;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             sag_q;

  // widen before negating so the most negative code keeps its magnitude
  always_comb begin
    if (sample_i[SAMPLE_W-1]) mag = ~{1'b1, sample_i} + 1'b1;
    else                      mag = {1'b0, sample_i};
  end

  assign is_low  = mag < {1'b0, thresh_i};
  assign limit   = (count_i == '0) ? CNT_W'(1) : count_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sag_q <= 1'b0;
    end else if (strobe_i) begin
      if (!is_low) begin
        cnt_q <= '0;
        sag_q <= 1'b0;
      end else begin
        if (cnt_q < limit) cnt_q <= cnt_inc[CNT_W-1:0];
        if (cnt_inc >= {1'b0, limit}) sag_q <= 1'b1;
      end
    end
  end

  assign sag_o = sag_q;

  a_r4_clear_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !is_low |=> !sag_q);
  a_r5_first_low_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && is_low && count_i <= CNT_W'(1) |=> sag_q);
  a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sag_q));
  a_r3_stays_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && is_low && sag_q |=> sag_q);
endmodule

// File: rtl/fund_square.sv
module fund_square #(
  parameter int SAMPLE_W = 16,
  parameter int HYST     = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       wave_o
);
  logic above, below, wave_q;
  int   s_val;

  assign s_val = int'(sample_i);
  assign above = s_val > HYST;
  assign below = s_val < -HYST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wave_q <= 1'b0;
    else if (strobe_i && above) wave_q <= 1'b1;
    else if (strobe_i && below) wave_q <= 1'b0;
  end

  assign wave_o = wave_q;

  a_r7_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && above |=> wave_q);
  a_r7_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && below |=> !wave_q);
  a_r7_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && (above || below)) |=> $stable(wave_q));
endmodule

// File: rtl/sag_status_monitor.sv
module sag_status_monitor
  import sag_mon_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16,
  parameter int HYST     = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] samp_a_i,
  input  logic signed [SAMPLE_W-1:0] samp_b_i,
  input  logic signed [SAMPLE_W-1:0] samp_c_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  input  logic        [CNT_W-1:0]    count_i,
  output logic [STATUS_W-1:0]        status_o,
  output logic                       irq_o
);
  logic signed [SAMPLE_W-1:0] samp [NUM_PH];
  logic [NUM_PH-1:0]          sag;
  logic                       wave;
  logic                       done_q, irq_q;
  logic [STATUS_W-1:0]        status_q;

  assign samp[0] = samp_a_i;
  assign samp[1] = samp_b_i;
  assign samp[2] = samp_c_i;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    sag_phase_det #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .sample_i (samp[p]),
      .thresh_i (thresh_i),
      .count_i  (count_i),
      .sag_o    (sag[p])
    );
  end

  fund_square #(.SAMPLE_W(SAMPLE_W), .HYST(HYST)) u_fund (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .sample_i (samp_a_i),
    .wave_o   (wave)
  );

  // pass ends one clock after the strobe; latch and flag it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= strobe_i;
      irq_q  <= done_q;
      if (done_q) status_q <= {{(STATUS_W-USED_BITS){1'b0}}, wave, sag};
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STATUS_W-1:USED_BITS] == '0);
  a_r8_stable_no_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |=> $stable(status_o));
  a_r9_irq_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ##1 irq_o);
  a_r9_irq_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ##1 !irq_o);
endmodule

// File: tb/sag_status_monitor_tb_top.sv
module sag_status_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HYST       = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               strobe = 1'b0;
  logic signed [15:0] sa = '0, sb = '0, sc = '0;
  logic [15:0]        thr = '0, cnt = '0;
  logic [31:0]        status;
  logic               irq;

  int errors = 0, checks = 0;
  int run [3];
  logic exp_wave = 1'b0;
  logic [31:0] exp_status = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sag_status_monitor #(.SAMPLE_W(16), .CNT_W(16), .HYST(HYST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe),
    .samp_a_i(sa), .samp_b_i(sb), .samp_c_i(sc),
    .thresh_i(thr), .count_i(cnt),
    .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model(input int a, input int b, input int c);
    int v [3];
    int lim;
    logic [2:0] fl;
    v[0] = a; v[1] = b; v[2] = c;
    lim = (cnt == 0) ? 1 : int'(cnt);
    for (int p = 0; p < 3; p++) begin
      int m;
      m = (v[p] < 0) ? -v[p] : v[p];
      if (m < int'(thr)) run[p]++;
      else run[p] = 0;
      fl[p] = (run[p] >= lim);
    end
    if (a > HYST) exp_wave = 1'b1;
    else if (a < -HYST) exp_wave = 1'b0;
    exp_status = {28'd0, exp_wave, fl};
  endtask

  // one pass; flag tag names the requirement the flags field is checked against
  task automatic pass(input int a, input int b, input int c, input string tag);
    logic [31:0] prev;
    prev = exp_status;
    @(negedge clk);
    sa = 16'(a); sb = 16'(b); sc = 16'(c); strobe = 1'b1;
    model(a, b, c);
    @(negedge clk);
    strobe = 1'b0;
    chk("R8", status, prev);
    @(negedge clk);
    chk("R2", {4'd0, status[31:4]}, 32'd0);
    chk(tag, {29'd0, status[2:0]}, {29'd0, exp_status[2:0]});
    chk("R7", {31'd0, status[3]}, {31'd0, exp_status[3]});
    chk("R9", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R9", {31'd0, irq}, 32'd0);
    chk("R8", status, exp_status);
  endtask

  task automatic clear_runs();
    for (int p = 0; p < 3; p++) run[p] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    clear_runs();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1", status, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // R3/R5: sweep count 0..6, each phase with its own low-run length
    thr = 16'd1000;
    for (int n = 0; n <= 6; n++) begin
      cnt = 16'(n);
      pass(5000, 5000, 5000, "R4");
      for (int k = 0; k < 8; k++) begin
        int b, c;
        b = (k < 3) ? -200 : 3000;
        c = (k % 4 == 3) ? 1000 : 999;
        pass(-500, b, c, (n <= 1) ? "R5" : "R3");
      end
    end

    // R10: one phase low at a time
    cnt = 16'd2;
    pass(5000, 5000, 5000, "R4");
    pass(10, 5000, 5000, "R10"); pass(10, 5000, 5000, "R10");
    pass(5000, 10, 5000, "R10"); pass(5000, 10, 5000, "R10");
    pass(5000, 5000, 10, "R10"); pass(5000, 5000, 10, "R10");

    // R6: negative extremes and magnitude equal to the threshold
    thr = 16'd32768; cnt = 16'd1;
    pass(-32768, -32767, 32767, "R6");
    thr = 16'd1000;
    pass(-1000, -999, 1000, "R6");
    thr = 16'd0;
    pass(0, 0, 0, "R4");

    // R7: phase A walking through the hysteresis band
    thr = 16'd100; cnt = 16'd3;
    for (int k = -80; k <= 80; k += 4) pass(k, 0, 0, "R7");
    for (int k = 80; k >= -80; k -= 4) pass(k, 0, 0, "R7");
    pass(HYST, 0, 0, "R7"); pass(HYST + 1, 0, 0, "R7");
    pass(-HYST, 0, 0, "R7"); pass(-HYST - 1, 0, 0, "R7");

    // R8: idle cycles keep the status word
    repeat (5) begin
      @(negedge clk);
      chk("R8", status, exp_status);
      chk("R9", {31'd0, irq}, 32'd0);
    end

    // pseudo-random passes with changing count
    lfsr = 32'h1ACE_B00C;
    thr = 16'd12000;
    for (int blk = 0; blk < 12; blk++) begin
      cnt = 16'(blk % 5);
      for (int k = 0; k < 40; k++) begin
        int a, b, c;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a = int'($signed(lfsr[15:0]));
        b = int'($signed(lfsr[23:8]));
        c = int'($signed(lfsr[31:16])) / 2;
        pass(a, b, c, "R3");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule